// File: doc/BRIEF.md
# Neural Inference Transaction Table

This block keeps track of neural-network inference requests that several software processes issue to one shared compute engine. Each request is a transaction: a process names the network it wants run, hands over an input vector one word at a time, and later polls for the result. The table allocates a slot for each transaction and records who owns it. It moves each slot through its lifecycle, offers fully loaded slots to the engine, captures the engine's result and hands it back to the owner on a poll.

A slot is addressed by the pair (address-space ID, transaction ID). The transaction ID is the slot number that the table returns when it accepts a new request. A command whose address space does not own the named slot is refused. Processes therefore cannot touch each other's work, even though all of it flows through the same engine. Ready slots are issued to the engine in round-robin order, so transactions from different owners interleave.

Commands arrive on one port, one per cycle. Each accepted command gets exactly one registered response. The engine side has a valid/ready issue channel and a one-cycle completion strobe.

Top module: `nn_txn_table`

## Requirements
- R1: After reset no response is valid, nothing is offered to the engine, and every slot is free.
- R2: A new-request command (op 0) carries the network ID in `cmd_nnid` and the input count in `cmd_data`. It claims the lowest-numbered free slot in state loading and answers code 0 (OK) with that slot's transaction ID in `rsp_data`.
- R3: A new request is answered with code 3 (error) and claims nothing when every slot is occupied or when the input count lies outside 1..IN_DEPTH.
- R4: A write, a poll or a reserved-op (op 3) command is answered with code 3 and changes no slot when `cmd_tid` names a free slot, a slot number at or above ENTRIES, or a slot owned by another address space.
- R5: A write (op 1) to a loading slot stores `cmd_data` as the next input word and answers code 0. A write to a slot in any other state answers code 3. The slot turns ready once the requested number of words has arrived.
- R6: When any slot is ready, `eng_valid` is high and `eng_tid`, `eng_nnid` and `eng_inputs` describe one ready slot. Input word k sits at bits [k*DATA_W +: DATA_W], and words never written read as zero. The offered slot becomes running on the cycle `eng_valid` and `eng_ready` are both high.
- R7: After the engine accepts slot i, the next slot offered is the first ready slot after i in cyclic slot order, not the lowest-numbered one.
- R8: A completion strobe stores `done_data` into the named slot and moves it to done, but only if that slot is running. A strobe for a slot in any other state has no effect.
- R9: A poll (op 2) of a done slot answers code 2 with the stored result and frees the slot. A poll of a slot that is loading, ready or running answers code 1 (pending).
- R10: Every command produces exactly one response, in the cycle after it is presented, and no response appears without a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 new, 1 write, 2 poll, 3 reserved |
| cmd_asid | input | ASID_W | Address space issuing the command |
| cmd_tid | input | clog2(ENTRIES) | Target transaction (slot) ID |
| cmd_nnid | input | NNID_W | Network ID for a new request |
| cmd_data | input | DATA_W | Input count (new) or input word (write) |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 2 | 0 OK, 1 pending, 2 data, 3 error |
| rsp_data | output | DATA_W | Transaction ID or result |
| eng_valid | output | 1 | A ready transaction is offered |
| eng_ready | input | 1 | Engine takes the offered transaction |
| eng_tid | output | clog2(ENTRIES) | Offered transaction ID |
| eng_nnid | output | NNID_W | Offered network ID |
| eng_inputs | output | IN_DEPTH*DATA_W | Offered input vector |
| done_valid | input | 1 | Engine completion strobe |
| done_tid | input | clog2(ENTRIES) | Completed transaction ID |
| done_data | input | DATA_W | Result word |

## Verification
The bench builds the table with three slots and an input depth of two. A handful of commands is then enough to fill the table and hit the full-table refusal. Because three is not a power of two, a two-bit transaction ID can name slot 3, which does not exist, so the out-of-range path is exercised. Three slots also make the round-robin pointer wrap past a freshly re-allocated lower slot. That case separates cyclic issue from lowest-first issue, and a count of one against a depth of two shows the zero fill of unwritten words.

// File: rtl/nntt_pkg.sv
package nntt_pkg;

  typedef enum logic [2:0] {
    ST_FREE  = 3'd0,
    ST_LOAD  = 3'd1,
    ST_READY = 3'd2,
    ST_RUN   = 3'd3,
    ST_DONE  = 3'd4
  } slot_state_e;

  typedef enum logic [1:0] {
    OP_NEW   = 2'd0,
    OP_WRITE = 2'd1,
    OP_POLL  = 2'd2,
    OP_RSVD  = 2'd3
  } cmd_op_e;

  typedef enum logic [1:0] {
    RSP_OK   = 2'd0,
    RSP_PEND = 2'd1,
    RSP_DATA = 2'd2,
    RSP_ERR  = 2'd3
  } rsp_code_e;

endpackage

// File: rtl/nntt_rr_arb.sv
module nntt_rr_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] gidx,
  output logic          any
);

  logic [IW-1:0] ptr_q, ptr_d;

  // search starts at the pointer and wraps once around the slots
  always_comb begin
    grant = '0;
    gidx  = '0;
    any   = 1'b0;
    for (int off = 0; off < N; off++) begin
      int j;
      j = int'(ptr_q) + off;
      if (j >= N) j = j - N;
      if (!any && req[j]) begin
        any      = 1'b1;
        grant[j] = 1'b1;
        gidx     = IW'(j);
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (adv && any) begin
      ptr_d = (gidx == IW'(N - 1)) ? '0 : gidx + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  a_r6_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  a_r7_grant_only_requesters: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);

endmodule

// File: rtl/nntt_slot.sv
module nntt_slot
  import nntt_pkg::*;
#(
  parameter int ASID_W   = 8,
  parameter int NNID_W   = 8,
  parameter int DATA_W   = 16,
  parameter int IN_DEPTH = 4,
  localparam int CNT_W   = $clog2(IN_DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       alloc_en,
  input  logic [ASID_W-1:0]          alloc_asid,
  input  logic [NNID_W-1:0]          alloc_nnid,
  input  logic [CNT_W-1:0]           alloc_cnt,
  input  logic                       wr_en,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       issue_en,
  input  logic                       done_en,
  input  logic [DATA_W-1:0]          done_data,
  input  logic                       free_en,
  output slot_state_e                st,
  output logic [ASID_W-1:0]          asid,
  output logic [NNID_W-1:0]          nnid,
  output logic [IN_DEPTH*DATA_W-1:0] inputs,
  output logic [DATA_W-1:0]          result
);

  slot_state_e                      st_q, st_d;
  logic [ASID_W-1:0]                asid_q, asid_d;
  logic [NNID_W-1:0]                nnid_q, nnid_d;
  logic [CNT_W-1:0]                 need_q, need_d;
  logic [CNT_W-1:0]                 wptr_q, wptr_d;
  logic [IN_DEPTH-1:0][DATA_W-1:0]  buf_q, buf_d;
  logic [DATA_W-1:0]                res_q, res_d;

  always_comb begin
    st_d   = st_q;
    asid_d = asid_q;
    nnid_d = nnid_q;
    need_d = need_q;
    wptr_d = wptr_q;
    buf_d  = buf_q;
    res_d  = res_q;
    if (alloc_en) begin
      st_d   = ST_LOAD;
      asid_d = alloc_asid;
      nnid_d = alloc_nnid;
      need_d = alloc_cnt;
      wptr_d = '0;
      buf_d  = '0;
    end
    if (wr_en) begin
      for (int k = 0; k < IN_DEPTH; k++) begin
        if (wptr_q == CNT_W'(k)) buf_d[k] = wr_data;
      end
      wptr_d = wptr_q + CNT_W'(1);
      if (wptr_q + CNT_W'(1) == need_q) st_d = ST_READY;
    end
    if (issue_en) st_d = ST_RUN;
    if (done_en) begin
      st_d  = ST_DONE;
      res_d = done_data;
    end
    if (free_en) st_d = ST_FREE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_FREE;
      asid_q <= '0;
      nnid_q <= '0;
      need_q <= '0;
      wptr_q <= '0;
      buf_q  <= '0;
      res_q  <= '0;
    end else begin
      st_q   <= st_d;
      asid_q <= asid_d;
      nnid_q <= nnid_d;
      need_q <= need_d;
      wptr_q <= wptr_d;
      buf_q  <= buf_d;
      res_q  <= res_d;
    end
  end

  assign st     = st_q;
  assign asid   = asid_q;
  assign nnid   = nnid_q;
  assign inputs = buf_q;
  assign result = res_q;

  a_r2_alloc_from_free: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> st_q == ST_FREE);
  a_r5_wptr_below_need: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_LOAD |-> wptr_q < need_q);
  a_r5_write_only_loading: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> st_q == ST_LOAD);
  a_r6_issue_only_ready: assert property (@(posedge clk) disable iff (!rst_n)
    issue_en |=> st_q == ST_RUN);
  a_r8_done_only_running: assert property (@(posedge clk) disable iff (!rst_n)
    done_en |-> st_q == ST_RUN);
  a_r9_poll_frees: assert property (@(posedge clk) disable iff (!rst_n)
    free_en |=> st_q == ST_FREE);

endmodule

// File: rtl/nn_txn_table.sv
module nn_txn_table
  import nntt_pkg::*;
#(
  parameter int ENTRIES  = 4,
  parameter int ASID_W   = 8,
  parameter int NNID_W   = 8,
  parameter int DATA_W   = 16,
  parameter int IN_DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  input  logic [1:0]                   cmd_op,
  input  logic [ASID_W-1:0]            cmd_asid,
  input  logic [$clog2(ENTRIES)-1:0]   cmd_tid,
  input  logic [NNID_W-1:0]            cmd_nnid,
  input  logic [DATA_W-1:0]            cmd_data,
  output logic                         rsp_valid,
  output logic [1:0]                   rsp_code,
  output logic [DATA_W-1:0]            rsp_data,
  output logic                         eng_valid,
  input  logic                         eng_ready,
  output logic [$clog2(ENTRIES)-1:0]   eng_tid,
  output logic [NNID_W-1:0]            eng_nnid,
  output logic [IN_DEPTH*DATA_W-1:0]   eng_inputs,
  input  logic                         done_valid,
  input  logic [$clog2(ENTRIES)-1:0]   done_tid,
  input  logic [DATA_W-1:0]            done_data
);

  localparam int TID_W = $clog2(ENTRIES);
  localparam int CNT_W = $clog2(IN_DEPTH + 1);

  // reset: asserted asynchronously, released through two flops
  logic rst_s1, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1   <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_s1   <= 1'b1;
      rst_sync <= rst_s1;
    end
  end

  slot_state_e                       s_st    [ENTRIES];
  logic [ASID_W-1:0]                 s_asid  [ENTRIES];
  logic [NNID_W-1:0]                 s_nnid  [ENTRIES];
  logic [IN_DEPTH*DATA_W-1:0]        s_in    [ENTRIES];
  logic [DATA_W-1:0]                 s_res   [ENTRIES];

  logic [ENTRIES-1:0] alloc_v, wr_v, issue_v, done_v, free_v, ready_v, idle_v;
  logic [ENTRIES-1:0] grant;
  logic [TID_W-1:0]   gidx;
  logic               gany;

  generate
    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      nntt_slot #(
        .ASID_W(ASID_W), .NNID_W(NNID_W), .DATA_W(DATA_W), .IN_DEPTH(IN_DEPTH)
      ) i_slot (
        .clk        (clk),
        .rst_n      (rst_sync),
        .alloc_en   (alloc_v[i]),
        .alloc_asid (cmd_asid),
        .alloc_nnid (cmd_nnid),
        .alloc_cnt  (cmd_data[CNT_W-1:0]),
        .wr_en      (wr_v[i]),
        .wr_data    (cmd_data),
        .issue_en   (issue_v[i]),
        .done_en    (done_v[i]),
        .done_data  (done_data),
        .free_en    (free_v[i]),
        .st         (s_st[i]),
        .asid       (s_asid[i]),
        .nnid       (s_nnid[i]),
        .inputs     (s_in[i]),
        .result     (s_res[i])
      );
      assign ready_v[i] = (s_st[i] == ST_READY);
      assign idle_v[i]  = (s_st[i] == ST_FREE);
      assign done_v[i]  = done_valid && (done_tid == TID_W'(i)) && (s_st[i] == ST_RUN);
      assign issue_v[i] = grant[i] && eng_ready;
    end
  endgenerate

  nntt_rr_arb #(.N(ENTRIES)) i_arb (
    .clk   (clk),
    .rst_n (rst_sync),
    .req   (ready_v),
    .adv   (eng_ready),
    .grant (grant),
    .gidx  (gidx),
    .any   (gany)
  );

  // engine offer: mux of the granted slot
  always_comb begin
    eng_nnid   = '0;
    eng_inputs = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (grant[i]) begin
        eng_nnid   = s_nnid[i];
        eng_inputs = s_in[i];
      end
    end
  end
  assign eng_valid = gany;
  assign eng_tid   = gidx;

  // command lookup
  logic                 sel_hit;
  slot_state_e          sel_st;
  logic [ASID_W-1:0]    sel_asid;
  logic [DATA_W-1:0]    sel_res;
  logic                 owned;
  logic                 any_idle;
  logic [TID_W-1:0]     idle_idx;
  logic                 cnt_ok;

  always_comb begin
    sel_hit  = 1'b0;
    sel_st   = ST_FREE;
    sel_asid = '0;
    sel_res  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (cmd_tid == TID_W'(i)) begin
        sel_hit  = 1'b1;
        sel_st   = s_st[i];
        sel_asid = s_asid[i];
        sel_res  = s_res[i];
      end
    end
    owned = sel_hit && (sel_st != ST_FREE) && (sel_asid == cmd_asid);
  end

  always_comb begin
    any_idle = 1'b0;
    idle_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (idle_v[i]) begin
        any_idle = 1'b1;
        idle_idx = TID_W'(i);
      end
    end
  end

  assign cnt_ok = (cmd_data != '0) && (cmd_data <= DATA_W'(IN_DEPTH));

  rsp_code_e          code_d;
  logic [DATA_W-1:0]  data_d;

  always_comb begin
    code_d  = RSP_ERR;
    data_d  = '0;
    alloc_v = '0;
    wr_v    = '0;
    free_v  = '0;
    if (cmd_valid) begin
      case (cmd_op_e'(cmd_op))
        OP_NEW: begin
          if (any_idle && cnt_ok) begin
            code_d = RSP_OK;
            data_d = DATA_W'(idle_idx);
            for (int i = 0; i < ENTRIES; i++)
              if (idle_idx == TID_W'(i)) alloc_v[i] = 1'b1;
          end
        end
        OP_WRITE: begin
          if (owned && sel_st == ST_LOAD) begin
            code_d = RSP_OK;
            for (int i = 0; i < ENTRIES; i++)
              if (cmd_tid == TID_W'(i)) wr_v[i] = 1'b1;
          end
        end
        OP_POLL: begin
          if (owned) begin
            if (sel_st == ST_DONE) begin
              code_d = RSP_DATA;
              data_d = sel_res;
              for (int i = 0; i < ENTRIES; i++)
                if (cmd_tid == TID_W'(i)) free_v[i] = 1'b1;
            end else begin
              code_d = RSP_PEND;
            end
          end
        end
        default: code_d = RSP_ERR;
      endcase
    end
  end

  logic               rsp_valid_q;
  rsp_code_e          rsp_code_q;
  logic [DATA_W-1:0]  rsp_data_q;

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      rsp_valid_q <= 1'b0;
      rsp_code_q  <= RSP_OK;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= cmd_valid;
      if (cmd_valid) begin
        rsp_code_q <= code_d;
        rsp_data_q <= data_d;
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_code  = rsp_code_q;
  assign rsp_data  = rsp_data_q;

  a_r10_rsp_after_cmd: assert property (@(posedge clk) disable iff (!rst_sync)
    cmd_valid |=> rsp_valid);
  a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_sync)
    !cmd_valid |=> !rsp_valid);
  a_r3_full_refused: assert property (@(posedge clk) disable iff (!rst_sync)
    (cmd_valid && cmd_op == 2'd0 && idle_v == '0) |=> rsp_code == 2'd3);
  a_r4_foreign_refused: assert property (@(posedge clk) disable iff (!rst_sync)
    (cmd_valid && cmd_op != 2'd0 && sel_hit && sel_asid != cmd_asid) |=> rsp_code == 2'd3);
  a_r6_offer_is_ready: assert property (@(posedge clk) disable iff (!rst_sync)
    eng_valid |-> s_st[eng_tid] == ST_READY);

endmodule

// File: tb/test_nn_txn_table.sv
module test_nn_txn_table;

  localparam int ENT = 3;
  localparam int DEP = 2;
  localparam int AW  = 4;
  localparam int NW  = 4;
  localparam int DW  = 16;
  localparam int TW  = $clog2(ENT);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid;
  logic [1:0]    cmd_op;
  logic [AW-1:0] cmd_asid;
  logic [TW-1:0] cmd_tid;
  logic [NW-1:0] cmd_nnid;
  logic [DW-1:0] cmd_data;
  logic          rsp_valid;
  logic [1:0]    rsp_code;
  logic [DW-1:0] rsp_data;
  logic          eng_valid;
  logic          eng_ready;
  logic [TW-1:0] eng_tid;
  logic [NW-1:0] eng_nnid;
  logic [DEP*DW-1:0] eng_inputs;
  logic          done_valid;
  logic [TW-1:0] done_tid;
  logic [DW-1:0] done_data;

  always #2 clk = ~clk;

  nn_txn_table #(.ENTRIES(ENT), .ASID_W(AW), .NNID_W(NW), .DATA_W(DW), .IN_DEPTH(DEP)) i_nn_txn_table (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_asid(cmd_asid),
    .cmd_tid(cmd_tid), .cmd_nnid(cmd_nnid), .cmd_data(cmd_data), .rsp_valid(rsp_valid),
    .rsp_code(rsp_code), .rsp_data(rsp_data), .eng_valid(eng_valid), .eng_ready(eng_ready),
    .eng_tid(eng_tid), .eng_nnid(eng_nnid), .eng_inputs(eng_inputs), .done_valid(done_valid),
    .done_tid(done_tid), .done_data(done_data)
  );

  int checks = 0;
  int errors = 0;

  logic [1:0]    q_code[$];
  logic [DW-1:0] q_data[$];
  string         q_tag[$];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: one expected item per response
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid) begin
        if (q_code.size() == 0) begin
          chk("R10 response without command", 64'd1, 64'd0);
        end else begin
          logic [1:0] ec;
          logic [DW-1:0] ed;
          string t;
          ec = q_code.pop_front();
          ed = q_data.pop_front();
          t  = q_tag.pop_front();
          chk({t, " code"}, 64'(rsp_code), 64'(ec));
          if (ec == 2'd0 || ec == 2'd2) chk({t, " data"}, 64'(rsp_data), 64'(ed));
        end
      end
    end
  end

  task automatic send(input logic [1:0] op, input logic [AW-1:0] a, input logic [TW-1:0] t,
                      input logic [NW-1:0] n, input logic [DW-1:0] d,
                      input logic [1:0] ec, input logic [DW-1:0] ed, input string tag);
    cmd_valid = 1'b1; cmd_op = op; cmd_asid = a; cmd_tid = t; cmd_nnid = n; cmd_data = d;
    q_code.push_back(ec); q_data.push_back(ed); q_tag.push_back(tag);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic take(input logic [TW-1:0] t, input logic [NW-1:0] n,
                      input logic [DEP*DW-1:0] v, input string tag);
    chk({tag, " eng_valid"}, 64'(eng_valid), 64'd1);
    chk({tag, " eng_tid"}, 64'(eng_tid), 64'(t));
    chk({tag, " eng_nnid"}, 64'(eng_nnid), 64'(n));
    chk({tag, " eng_inputs"}, 64'(eng_inputs), 64'(v));
    eng_ready = 1'b1;
    @(negedge clk);
    eng_ready = 1'b0;
  endtask

  task automatic finish_cmp(input logic [TW-1:0] t, input logic [DW-1:0] d);
    done_valid = 1'b1; done_tid = t; done_data = d;
    @(negedge clk);
    done_valid = 1'b0;
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_asid = '0; cmd_tid = '0;
    cmd_nnid = '0; cmd_data = '0; eng_ready = 1'b0; done_valid = 1'b0; done_tid = '0; done_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    chk("R1 eng_valid after reset", 64'(eng_valid), 64'd0);

    // fill the table
    send(2'd0, 4'd1, 2'd0, 4'd5, 16'd2, 2'd0, 16'd0, "R1 R2 first new gets slot 0");
    send(2'd0, 4'd2, 2'd0, 4'd6, 16'd1, 2'd0, 16'd1, "R2 second new gets slot 1");
    send(2'd0, 4'd3, 2'd0, 4'd7, 16'd0, 2'd3, 16'd0, "R3 zero count refused");
    send(2'd0, 4'd3, 2'd0, 4'd7, 16'd3, 2'd3, 16'd0, "R3 count above depth refused");
    send(2'd0, 4'd3, 2'd0, 4'd7, 16'd2, 2'd0, 16'd2, "R2 third new gets slot 2");
    send(2'd0, 4'd4, 2'd0, 4'd8, 16'd1, 2'd3, 16'd0, "R3 full table refused");

    // isolation and bad targets
    send(2'd1, 4'd2, 2'd0, 4'd0, 16'h1111, 2'd3, 16'd0, "R4 write by foreign asid");
    send(2'd2, 4'd1, 2'd3, 4'd0, 16'd0, 2'd3, 16'd0, "R4 out of range tid");
    send(2'd3, 4'd1, 2'd0, 4'd0, 16'd0, 2'd3, 16'd0, "R4 reserved op");
    send(2'd2, 4'd1, 2'd0, 4'd0, 16'd0, 2'd1, 16'd0, "R9 poll loading is pending");

    // load slot 0
    send(2'd1, 4'd1, 2'd0, 4'd0, 16'hA0A0, 2'd0, 16'd0, "R5 first word");
    chk("R5 not ready after partial load", 64'(eng_valid), 64'd0);
    send(2'd1, 4'd1, 2'd0, 4'd0, 16'hB0B0, 2'd0, 16'd0, "R5 last word");
    send(2'd1, 4'd1, 2'd0, 4'd0, 16'hC0C0, 2'd3, 16'd0, "R5 write to ready slot refused");
    send(2'd1, 4'd2, 2'd1, 4'd0, 16'h00C1, 2'd0, 16'd0, "R5 slot 1 word");
    send(2'd1, 4'd3, 2'd2, 4'd0, 16'h00D1, 2'd0, 16'd0, "R5 slot 2 word 0");
    send(2'd1, 4'd3, 2'd2, 4'd0, 16'h00D2, 2'd0, 16'd0, "R5 slot 2 word 1");

    take(2'd0, 4'd5, {16'hB0B0, 16'hA0A0}, "R6 issue slot 0");
    take(2'd1, 4'd6, {16'h0000, 16'h00C1}, "R6 R7 issue slot 1 zero fill");

    finish_cmp(2'd0, 16'h5A5A);
    send(2'd2, 4'd9, 2'd0, 4'd0, 16'd0, 2'd3, 16'd0, "R4 foreign poll of done slot");
    send(2'd2, 4'd1, 2'd0, 4'd0, 16'd0, 2'd2, 16'h5A5A, "R8 R9 poll done slot 0");
    send(2'd0, 4'd5, 2'd0, 4'd9, 16'd1, 2'd0, 16'd0, "R2 R9 freed slot 0 reused");
    send(2'd1, 4'd5, 2'd0, 4'd0, 16'h00F1, 2'd0, 16'd0, "R5 reload slot 0");

    // completion for a slot that is not running is dropped
    finish_cmp(2'd2, 16'hDEAD);
    take(2'd2, 4'd7, {16'h00D2, 16'h00D1}, "R7 R8 cyclic issue picks slot 2 over 0");
    take(2'd0, 4'd9, {16'h0000, 16'h00F1}, "R7 wrap to slot 0");
    chk("R6 nothing left to offer", 64'(eng_valid), 64'd0);

    send(2'd2, 4'd2, 2'd1, 4'd0, 16'd0, 2'd1, 16'd0, "R9 poll running is pending");
    finish_cmp(2'd1, 16'h1234);
    send(2'd2, 4'd2, 2'd1, 4'd0, 16'd0, 2'd2, 16'h1234, "R8 R9 poll slot 1");
    send(2'd2, 4'd2, 2'd1, 4'd0, 16'd0, 2'd3, 16'd0, "R4 poll of freed slot");
    finish_cmp(2'd2, 16'h2222);
    finish_cmp(2'd0, 16'h3333);
    send(2'd2, 4'd3, 2'd2, 4'd0, 16'd0, 2'd2, 16'h2222, "R8 slot 2 result not overwritten");
    send(2'd2, 4'd5, 2'd0, 4'd0, 16'd0, 2'd2, 16'h3333, "R9 slot 0 result");

    @(negedge clk);
    chk("R10 every command answered", 64'(q_code.size()), 64'd0);
    report();
  end

endmodule